// File: doc/BRIEF.md
# Register Window Control Unit

This block holds the windowed-register bookkeeping of a small processor core. It keeps a window-base pointer that selects which group of four physical registers is visible as the bottom of the current frame. It also keeps a window-start bitmap with one bit per group, marking where each live frame begins. The core sends it one request at a time: a call entry, a windowed return, a rotate by a signed amount, or a stack-move check. With each request it supplies the window-enable and exception-mode status bits, the caller increment and the return-address register. On the following clock edge the block presents the new base and bitmap, and for returns the computed return PC. It also raises an exception request with a cause code, a frame-size code and the old base to be saved in the status register.

Spill and fill of frames are detected by scanning the bitmap circularly. An entry whose frame would collide with a live frame above it raises an overflow. The window is advanced to the oldest live frame, and the size of that frame (4, 8 or 12 registers) is reported so that the handler can spill it. A return to a frame whose start bit is clear raises an underflow of the returning size. The physical register copy and the vector fetch belong to the surrounding core.

The control is organised around a registered outcome state. Its states are ST_IDLE, ST_ENTRY_DONE, ST_ENTRY_ILLEGAL, ST_OVERFLOW, ST_RETURN_DONE, ST_RETURN_ILLEGAL, ST_UNDERFLOW, ST_ROTATED, ST_ALLOCA and ST_STACK_OK. Every cycle the state moves to the outcome of the request presented on that edge, or to ST_IDLE when there is none. No state is held for more than one cycle unless a request of the same outcome follows.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window base is 0, the bitmap has only bit 0 set, and exc_valid, ret_valid and owb_wr are low.
- R2: An entry request (op code 0) whose stack-register operand exceeds 3, or that arrives without woe=1 and excm=0, reports cause code 1 (illegal) and leaves the base and the bitmap unchanged.
- R3: For a legal entry, the bitmap is read circularly starting at base+1. If any of the next callinc bits is set, the block reports cause code 3 (overflow), advances the base by one plus the number of clear bits before the first set one, leaves the bitmap unchanged, and pulses owb_wr with the old base on owb_val.
- R4: The overflow size code comes from the count of clear bits met when the bitmap is read circularly from the new base plus 1. A count of 0 gives code 1 (4 registers), a count of 1 gives code 2 (8 registers), and any larger count gives code 3 (12 registers).
- R5: A legal entry with no overflow advances the base by callinc and sets the bitmap bit of the new base, with no exception.
- R6: A return request (op code 1) reports cause code 1 and changes no state when any of these holds: the increment n in ret_addr[31:30] is 0; the nearest set bit among base-1, base-2, base-3 lies at a distance m other than n; or the status bits are not woe=1 and excm=0.
- R7: A return that completes raises ret_valid with ret_pc equal to pc_hi in bits 31:30 and ret_addr[29:0] below.
- R8: A completing return moves the base back by n and clears the bitmap bit of the old base, when the bit at the new base was set.
- R9: A legal return whose new-base bit is clear reports cause code 4 (underflow) with size code n, pulses owb_wr with the old base, still moves the base back by n, leaves the bitmap unchanged, and keeps ret_valid low.
- R10: A rotate request (op code 2) adds the signed 4-bit rot_amt to the base, with no exception and no bitmap change.
- R11: A stack-move check (op code 3) reports cause code 2 (alloca) when none of the bits at base-1, base-2 or base-3 is set, and no exception otherwise. It never changes state.
- R12: Results appear on the clock edge that samples the request. exc_valid, ret_valid and owb_wr are low in any cycle that follows an edge without a request.
- R13: All base arithmetic wraps modulo the number of groups, NUM_PHYS_REGS/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 entry, 1 return, 2 rotate, 3 stack-move check |
| stack_sel | input | 4 | Stack-register operand of an entry |
| rot_amt | input | 4 | Signed rotate amount in groups |
| callinc | input | 2 | Caller increment from the status register |
| ps_woe | input | 1 | Window-overflow enable status bit |
| ps_excm | input | 1 | Exception-mode status bit |
| ret_addr | input | 32 | Return-address register contents |
| pc_hi | input | 2 | Bits 31:30 of the current PC |
| win_base | output | BW | Current window base |
| win_start | output | NG | Window-start bitmap |
| exc_valid | output | 1 | Exception request pulse |
| exc_cause | output | 3 | 1 illegal, 2 alloca, 3 overflow, 4 underflow |
| exc_size | output | 2 | Window frame size code: 1, 2, 3 for 4, 8, 12 registers |
| owb_wr | output | 1 | Save owb_val to the status register and set exception mode |
| owb_val | output | BW | Old window base to be saved |
| ret_valid | output | 1 | Return completed |
| ret_pc | output | 32 | Computed return PC |

## Verification
The bench builds the block with NUM_PHYS_REGS set to 32, which gives eight groups and a 3-bit base. With this size, a short chain of entries reaches the top of the bitmap and wraps. This makes the overflow rescan cross index 7 to 0, and it lets rotate and underflow sequences exercise modular subtraction in a few requests. The chosen bitmap patterns yield each of the three overflow size codes. The return tests cover every illegal condition separately, next to a completing return and an underflow.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        OP_ENTRY    = 2'd0,
        OP_RETURN   = 2'd1,
        OP_ROTATE   = 2'd2,
        OP_STACKCHK = 2'd3
    } wop_e;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_ILLEGAL   = 3'd1,
        CAUSE_ALLOCA    = 3'd2,
        CAUSE_OVERFLOW  = 3'd3,
        CAUSE_UNDERFLOW = 3'd4
    } cause_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTRY_DONE,
        ST_ENTRY_ILLEGAL,
        ST_OVERFLOW,
        ST_RETURN_DONE,
        ST_RETURN_ILLEGAL,
        ST_UNDERFLOW,
        ST_ROTATED,
        ST_ALLOCA,
        ST_STACK_OK
    } wstate_e;

    localparam logic [1:0] SZ_FOUR   = 2'd1;
    localparam logic [1:0] SZ_EIGHT  = 2'd2;
    localparam logic [1:0] SZ_TWELVE = 2'd3;

endpackage

// File: rtl/regwin_rotr.sv
// Circular right rotation: dout[i] = din[(i + sh) mod N], N a power of two.
module regwin_rotr #(
    parameter int N  = 16,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  din,
    input  logic [SW-1:0] sh,
    output logic [N-1:0]  dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [SW-1:0] src;
        assign src     = SW'(i) + sh;
        assign dout[i] = din[src];
    end
endmodule

// File: rtl/regwin_ctz.sv
// Count of clear bits below the lowest set bit; N when the vector is zero.
module regwin_ctz #(
    parameter int N  = 16,
    localparam int CW = $clog2(N) + 1
) (
    input  logic [N-1:0]  din,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (din[i]) cnt = CW'(i);
        end
    end
endmodule

// File: rtl/regwin_decide.sv
// Combinational decision for one request: next outcome state and payload.
module regwin_decide
    import regwin_pkg::*;
#(
    parameter int NG = 16,
    localparam int BW = $clog2(NG),
    localparam int CW = BW + 1
) (
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [3:0]        stack_sel,
    input  logic signed [3:0] rot_amt,
    input  logic [1:0]        callinc,
    input  logic              ps_woe,
    input  logic              ps_excm,
    input  logic [31:0]       ret_addr,
    input  logic [1:0]        pc_hi,
    input  logic [BW-1:0]     base,
    input  logic [NG-1:0]     start,
    output wstate_e           nxt_state,
    output logic [BW-1:0]     nxt_base,
    output logic [NG-1:0]     nxt_start,
    output logic [1:0]        nxt_size,
    output logic [BW-1:0]     nxt_owb,
    output logic [31:0]       nxt_retpc
);
    // Circular scan above the current base.
    logic [NG-1:0] scan_cur;
    logic [CW-1:0] tz_cur;
    logic [BW-1:0] sh_cur;
    assign sh_cur = base + BW'(1);

    regwin_rotr #(.N(NG)) u_rot_cur (.din(start), .sh(sh_cur), .dout(scan_cur));
    regwin_ctz  #(.N(NG)) u_ctz_cur (.din(scan_cur), .cnt(tz_cur));

    // Overflow target and the rescan above it.
    logic [BW-1:0] ovf_base;
    logic [BW-1:0] sh_ovf;
    logic [NG-1:0] scan_ovf;
    logic [CW-1:0] tz_ovf;
    assign ovf_base = base + BW'(tz_cur) + BW'(1);
    assign sh_ovf   = ovf_base + BW'(1);

    regwin_rotr #(.N(NG)) u_rot_ovf (.din(start), .sh(sh_ovf), .dout(scan_ovf));
    regwin_ctz  #(.N(NG)) u_ctz_ovf (.din(scan_ovf), .cnt(tz_ovf));

    // Status legality shared by entry and return.
    logic ps_ok;
    assign ps_ok = ps_woe && !ps_excm;

    // Entry collision mask over the next callinc groups.
    logic [2:0] ci_mask;
    logic       ovf_hit;
    assign ci_mask = 3'((4'd1 << callinc) - 4'd1);
    assign ovf_hit = |(scan_cur[2:0] & ci_mask);

    // Distance to the nearest live frame below the base.
    logic [1:0] near_m;
    always_comb begin
        if (start[base - BW'(1)])      near_m = 2'd1;
        else if (start[base - BW'(2)]) near_m = 2'd2;
        else if (start[base - BW'(3)]) near_m = 2'd3;
        else                           near_m = 2'd0;
    end

    logic [1:0]    ret_n;
    logic [BW-1:0] ret_base;
    logic          ret_bad;
    assign ret_n    = ret_addr[31:30];
    assign ret_base = base - BW'(ret_n);
    assign ret_bad  = (ret_n == 2'd0) || ((near_m != 2'd0) && (near_m != ret_n)) || !ps_ok;

    logic [BW-1:0] ent_base;
    assign ent_base = base + BW'(callinc);

    always_comb begin
        nxt_state = ST_IDLE;
        nxt_base  = base;
        nxt_start = start;
        nxt_size  = 2'd0;
        nxt_owb   = base;
        nxt_retpc = {pc_hi, ret_addr[29:0]};
        if (req_valid) begin
            unique case (wop_e'(req_op))
                OP_ENTRY: begin
                    if ((stack_sel > 4'd3) || !ps_ok) begin
                        nxt_state = ST_ENTRY_ILLEGAL;
                    end else if (ovf_hit) begin
                        nxt_state = ST_OVERFLOW;
                        nxt_base  = ovf_base;
                        if (tz_ovf == CW'(0))      nxt_size = SZ_FOUR;
                        else if (tz_ovf == CW'(1)) nxt_size = SZ_EIGHT;
                        else                       nxt_size = SZ_TWELVE;
                    end else begin
                        nxt_state           = ST_ENTRY_DONE;
                        nxt_base            = ent_base;
                        nxt_start[ent_base] = 1'b1;
                    end
                end
                OP_RETURN: begin
                    if (ret_bad) begin
                        nxt_state = ST_RETURN_ILLEGAL;
                    end else if (start[ret_base]) begin
                        nxt_state       = ST_RETURN_DONE;
                        nxt_base        = ret_base;
                        nxt_start[base] = 1'b0;
                    end else begin
                        nxt_state = ST_UNDERFLOW;
                        nxt_base  = ret_base;
                        nxt_size  = ret_n;
                    end
                end
                OP_ROTATE: begin
                    nxt_state = ST_ROTATED;
                    nxt_base  = base + BW'(rot_amt);
                end
                OP_STACKCHK: begin
                    nxt_state = (near_m == 2'd0) ? ST_ALLOCA : ST_STACK_OK;
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NUM_PHYS_REGS = 64,
    localparam int NG = NUM_PHYS_REGS / 4,
    localparam int BW = $clog2(NG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [3:0]        stack_sel,
    input  logic signed [3:0] rot_amt,
    input  logic [1:0]        callinc,
    input  logic              ps_woe,
    input  logic              ps_excm,
    input  logic [31:0]       ret_addr,
    input  logic [1:0]        pc_hi,
    output logic [BW-1:0]     win_base,
    output logic [NG-1:0]     win_start,
    output logic              exc_valid,
    output logic [2:0]        exc_cause,
    output logic [1:0]        exc_size,
    output logic              owb_wr,
    output logic [BW-1:0]     owb_val,
    output logic              ret_valid,
    output logic [31:0]       ret_pc
);
    wstate_e       state_q, state_d;
    logic [BW-1:0] base_q, base_d;
    logic [NG-1:0] start_q, start_d;
    logic [1:0]    size_q, size_d;
    logic [BW-1:0] owb_q, owb_d;
    logic [31:0]   retpc_q, retpc_d;

    regwin_decide #(.NG(NG)) u_decide (
        .req_valid (req_valid),
        .req_op    (req_op),
        .stack_sel (stack_sel),
        .rot_amt   (rot_amt),
        .callinc   (callinc),
        .ps_woe    (ps_woe),
        .ps_excm   (ps_excm),
        .ret_addr  (ret_addr),
        .pc_hi     (pc_hi),
        .base      (base_q),
        .start     (start_q),
        .nxt_state (state_d),
        .nxt_base  (base_d),
        .nxt_start (start_d),
        .nxt_size  (size_d),
        .nxt_owb   (owb_d),
        .nxt_retpc (retpc_d)
    );

    // State and window registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            start_q <= NG'(1);
            size_q  <= '0;
            owb_q   <= '0;
            retpc_q <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            start_q <= start_d;
            size_q  <= size_d;
            owb_q   <= owb_d;
            retpc_q <= retpc_d;
        end
    end

    // Outputs decoded from the outcome state.
    always_comb begin
        exc_valid = 1'b0;
        exc_cause = CAUSE_NONE;
        owb_wr    = 1'b0;
        ret_valid = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ENTRY_DONE, ST_ROTATED, ST_STACK_OK: ;
            ST_ENTRY_ILLEGAL, ST_RETURN_ILLEGAL: begin
                exc_valid = 1'b1;
                exc_cause = CAUSE_ILLEGAL;
            end
            ST_OVERFLOW: begin
                exc_valid = 1'b1;
                exc_cause = CAUSE_OVERFLOW;
                owb_wr    = 1'b1;
            end
            ST_UNDERFLOW: begin
                exc_valid = 1'b1;
                exc_cause = CAUSE_UNDERFLOW;
                owb_wr    = 1'b1;
            end
            ST_RETURN_DONE: ret_valid = 1'b1;
            ST_ALLOCA: begin
                exc_valid = 1'b1;
                exc_cause = CAUSE_ALLOCA;
            end
            default: ;
        endcase
    end

    assign win_base  = base_q;
    assign win_start = start_q;
    assign exc_size  = size_q;
    assign owb_val   = owb_q;
    assign ret_pc    = retpc_q;

    AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == CAUSE_ILLEGAL) |-> ($stable(win_base) && $stable(win_start))); // R2
    AST_OVF_SIZE_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == CAUSE_OVERFLOW) |-> (exc_size != 2'd0 && owb_wr)); // R4
    AST_UNF_KEEPS_BITMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_cause == CAUSE_UNDERFLOW) |-> ($stable(win_start) && !ret_valid)); // R9
    AST_RETPC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> (ret_pc[29:0] == $past(ret_addr[29:0]))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!exc_valid && !ret_valid && !owb_wr)); // R12
    AST_BITMAP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_start != '0); // R8
    AST_ROTATE_KEEPS_BITMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_ROTATE) |=> ($stable(win_start) && !exc_valid)); // R10
endmodule

// File: tb/regwin_ctrl_bench.sv
module regwin_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPR = 32;
    localparam int NG  = NPR / 4;
    localparam int BW  = $clog2(NG);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic [3:0]        stack_sel = '0;
    logic signed [3:0] rot_amt = '0;
    logic [1:0]        callinc = '0;
    logic              ps_woe = 1'b1;
    logic              ps_excm = 1'b0;
    logic [31:0]       ret_addr = '0;
    logic [1:0]        pc_hi = '0;
    logic [BW-1:0]     win_base;
    logic [NG-1:0]     win_start;
    logic              exc_valid;
    logic [2:0]        exc_cause;
    logic [1:0]        exc_size;
    logic              owb_wr;
    logic [BW-1:0]     owb_val;
    logic              ret_valid;
    logic [31:0]       ret_pc;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    regwin_ctrl #(.NUM_PHYS_REGS(NPR)) u_regwin_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .stack_sel(stack_sel), .rot_amt(rot_amt), .callinc(callinc),
        .ps_woe(ps_woe), .ps_excm(ps_excm), .ret_addr(ret_addr), .pc_hi(pc_hi),
        .win_base(win_base), .win_start(win_start), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .exc_size(exc_size), .owb_wr(owb_wr),
        .owb_val(owb_val), .ret_valid(ret_valid), .ret_pc(ret_pc)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Presents one request at a negedge; results are visible at the next negedge.
    task automatic issue(input logic [1:0] op, input logic [3:0] s, input logic signed [3:0] r,
                         input logic [1:0] ci, input logic [31:0] a0, input logic [1:0] ph,
                         input logic woe_i, input logic excm_i);
        req_valid = 1'b1; req_op = op; stack_sel = s; rot_amt = r; callinc = ci;
        ret_addr = a0; pc_hi = ph; ps_woe = woe_i; ps_excm = excm_i;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_state(input string req, input int b, input int st);
        check(req, "win_base", 32'(win_base), 32'(b));
        check(req, "win_start", 32'(win_start), 32'(st));
    endtask

    task automatic t_reset();
        do_reset();
        expect_state("R1", 0, 'h01);
        check("R1", "exc_valid", 32'(exc_valid), 0);
        check("R1", "ret_valid", 32'(ret_valid), 0);
        check("R1", "owb_wr", 32'(owb_wr), 0);
    endtask

    task automatic t_entry_illegal();
        do_reset();
        issue(2'd0, 4'd4, 4'sd0, 2'd1, 0, 2'd0, 1'b1, 1'b0);
        check("R2", "cause operand>3", 32'(exc_cause), 1);
        expect_state("R2", 0, 'h01);
        issue(2'd0, 4'd1, 4'sd0, 2'd1, 0, 2'd0, 1'b0, 1'b0);
        check("R2", "cause woe=0", 32'(exc_cause), 1);
        issue(2'd0, 4'd1, 4'sd0, 2'd1, 0, 2'd0, 1'b1, 1'b1);
        check("R2", "cause excm=1", 32'(exc_cause), 1);
        check("R2", "exc_valid", 32'(exc_valid), 1);
        expect_state("R2", 0, 'h01);
    endtask

    task automatic t_entry_chain();
        do_reset();
        issue(2'd0, 4'd1, 4'sd0, 2'd1, 0, 2'd0, 1'b1, 1'b0);
        check("R5", "exc_valid ci1", 32'(exc_valid), 0);
        expect_state("R5", 1, 'h03);
        issue(2'd0, 4'd1, 4'sd0, 2'd2, 0, 2'd0, 1'b1, 1'b0);
        expect_state("R5", 3, 'h0B);
        issue(2'd0, 4'd1, 4'sd0, 2'd3, 0, 2'd0, 1'b1, 1'b0);
        expect_state("R5", 6, 'h4B);
        issue(2'd0, 4'd1, 4'sd0, 2'd3, 0, 2'd0, 1'b1, 1'b0);
        check("R3", "cause", 32'(exc_cause), 3);
        check("R3", "owb_wr", 32'(owb_wr), 1);
        check("R3", "owb_val", 32'(owb_val), 6);
        check("R4", "size four", 32'(exc_size), 1);
        check("R13", "base wraps to 0", 32'(win_base), 0);
        check("R3", "bitmap unchanged", 32'(win_start), 'h4B);
        @(negedge clk);
        check("R12", "exc_valid dropped", 32'(exc_valid), 0);
        check("R12", "owb_wr dropped", 32'(owb_wr), 0);
    endtask

    task automatic t_ovf_sizes();
        do_reset();
        issue(2'd0, 4'd0, 4'sd0, 2'd2, 0, 2'd0, 1'b1, 1'b0);
        issue(2'd0, 4'd0, 4'sd0, 2'd3, 0, 2'd0, 1'b1, 1'b0);
        expect_state("R5", 5, 'h25);
        issue(2'd2, 4'd0, 4'sd2, 2'd0, 0, 2'd0, 1'b1, 1'b0);
        check("R10", "rotate +2", 32'(win_base), 7);
        check("R10", "exc_valid", 32'(exc_valid), 0);
        issue(2'd0, 4'd0, 4'sd0, 2'd1, 0, 2'd0, 1'b1, 1'b0);
        check("R4", "size eight", 32'(exc_size), 2);
        check("R3", "owb_val", 32'(owb_val), 7);
        expect_state("R3", 0, 'h25);
        issue(2'd0, 4'd0, 4'sd0, 2'd3, 0, 2'd0, 1'b1, 1'b0);
        check("R3", "cause", 32'(exc_cause), 3);
        check("R4", "size twelve", 32'(exc_size), 3);
        check("R3", "owb_val", 32'(owb_val), 0);
        expect_state("R3", 2, 'h25);
    endtask

    task automatic t_return();
        do_reset();
        issue(2'd0, 4'd1, 4'sd0, 2'd1, 0, 2'd0, 1'b1, 1'b0);
        issue(2'd1, 4'd0, 4'sd0, 2'd0, 32'h4012_3456, 2'd3, 1'b1, 1'b0);
        check("R7", "ret_valid", 32'(ret_valid), 1);
        check("R7", "ret_pc", ret_pc, 32'hC012_3456);
        check("R8", "exc_valid", 32'(exc_valid), 0);
        expect_state("R8", 0, 'h01);
        issue(2'd1, 4'd0, 4'sd0, 2'd0, 32'h0000_0010, 2'd0, 1'b1, 1'b0);
        check("R6", "n=0 cause", 32'(exc_cause), 1);
        check("R6", "n=0 ret_valid", 32'(ret_valid), 0);
        issue(2'd0, 4'd1, 4'sd0, 2'd2, 0, 2'd0, 1'b1, 1'b0);
        expect_state("R5", 2, 'h05);
        issue(2'd1, 4'd0, 4'sd0, 2'd0, 32'h4000_0000, 2'd0, 1'b1, 1'b0);
        check("R6", "m!=n cause", 32'(exc_cause), 1);
        expect_state("R6", 2, 'h05);
        issue(2'd1, 4'd0, 4'sd0, 2'd0, 32'h8000_0ABC, 2'd1, 1'b0, 1'b0);
        check("R6", "woe=0 cause", 32'(exc_cause), 1);
        issue(2'd1, 4'd0, 4'sd0, 2'd0, 32'h8000_0ABC, 2'd1, 1'b1, 1'b0);
        check("R7", "ret_pc n=2", ret_pc, 32'h4000_0ABC);
        expect_state("R8", 0, 'h01);
    endtask

    task automatic t_underflow_rotate_stack();
        do_reset();
        issue(2'd2, 4'd0, 4'sd4, 2'd0, 0, 2'd0, 1'b1, 1'b0);
        check("R10", "rotate +4", 32'(win_base), 4);
        issue(2'd1, 4'd0, 4'sd0, 2'd0, 32'h4000_0100, 2'd0, 1'b1, 1'b0);
        check("R9", "cause", 32'(exc_cause), 4);
        check("R9", "size", 32'(exc_size), 1);
        check("R9", "owb_val", 32'(owb_val), 4);
        check("R9", "ret_valid", 32'(ret_valid), 0);
        expect_state("R9", 3, 'h01);
        issue(2'd2, 4'd0, -4'sd5, 2'd0, 0, 2'd0, 1'b1, 1'b0);
        check("R13", "rotate -5 wraps", 32'(win_base), 6);
        issue(2'd3, 4'd0, 4'sd0, 2'd0, 0, 2'd0, 1'b1, 1'b0);
        check("R11", "alloca cause", 32'(exc_cause), 2);
        expect_state("R11", 6, 'h01);
        issue(2'd2, 4'd0, -4'sd5, 2'd0, 0, 2'd0, 1'b1, 1'b0);
        check("R10", "rotate to 1", 32'(win_base), 1);
        issue(2'd3, 4'd0, 4'sd0, 2'd0, 0, 2'd0, 1'b1, 1'b0);
        check("R11", "live frame no exception", 32'(exc_valid), 0);
        expect_state("R11", 1, 'h01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_entry_illegal();
        t_entry_chain();
        t_ovf_sizes();
        t_return();
        t_underflow_rotate_stack();
        finish_run();
    end
endmodule